// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one direct-memory-access channel. It copies byte or halfword items between two places. The first place is a fixed peripheral address. The second is a memory pointer that steps up or down after every item. A memory-to-memory mode copies from a wide memory pointer to a second memory address. Software sets up the channel through a small register port. That port holds a control word, the item count, the fixed address, the stepping memory pointer and a flag word. The channel moves data only while its own enable bit and the chip-wide enable input are both high.

In the peripheral modes, each one-cycle pulse on the request input starts one item. In memory-to-memory mode, items follow one another with no request. Every item uses two single-beat bus accesses: a read, then a write. The count register goes down once per item. In normal mode, the channel disables itself when the count reaches zero. In circular mode, it reloads the count and the memory pointer from the values software last wrote. When the last item finishes, the transfer-complete flag is set. The flag stays set until software clears it. A bus error stops the channel and sets an error flag. Each flag can drive the interrupt output.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, every register reads zero, `bus_req` is low and `irq` is low.
- R2: Direction code 0 (control bits [2:1]) moves one item per request pulse. The item is read from the fixed address and written to the memory pointer. With no request pulse, no bus access happens.
- R3: Direction code 1 reads from the memory pointer and writes to the fixed address.
- R4: Direction code 2 moves items back to back with no request. The source is the full 24-bit memory pointer and the destination is the fixed address. In the other two directions, bus address bits [23:16] are always zero.
- R5: With control bit 4 clear, the memory pointer goes up by the item size after each item: 1 for bytes, 2 for halfwords. The fixed address never changes.
- R6: With control bit 4 set, the memory pointer goes down by the item size after each item.
- R7: Control bit 5 selects halfword items, shown as `bus_size`=1, and all 16 data bits are moved. For byte items, `bus_size`=0 and `bus_wdata[15:8]` is zero.
- R8: The count (register 1) goes down by one after each item and always reads back its current value. A write to it is ignored while control bit 0 (enable) is set.
- R9: In normal mode (control bit 3 clear), the item that brings the count to zero also clears the enable bit and sets the complete flag (flag bit 0). Later requests move nothing.
- R10: In circular mode, the item that brings the count to zero reloads the count and the memory pointer from their last written values, sets the complete flag and leaves the channel enabled.
- R11: While `glb_en` is low, no bus access starts, and request pulses are dropped rather than kept.
- R12: Writing 1 to flag bit 0 (register 4) clears it. `irq` is high while the complete flag and control bit 6 are both set.
- R13: A bus error response sets flag bit 1 and clears the enable bit. It leaves the count unchanged and skips the write beat. `irq` is high while flag bit 1 and control bit 7 are both set. Writing 1 to flag bit 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_en | input | 1 | Chip-wide DMA enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 count, 2 fixed address, 3 memory pointer, 4 flags |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, combinational on reg_addr |
| periph_req | input | 1 | Peripheral transfer request pulse |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 24 | Bus byte address |
| bus_size | output | 1 | 0 byte, 1 halfword |
| bus_wdata | output | 16 | Bus write data |
| bus_ack | input | 1 | Bus access completes this cycle |
| bus_rdata | input | 16 | Read data, valid with bus_ack |
| bus_err | input | 1 | Error response, valid with bus_ack |
| tc_flag | output | 1 | Transfer-complete flag |
| err_flag | output | 1 | Bus error flag |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count or a wrong pointer does not show up at once. It shows on the bus address or on the reload point one item later, or after a whole buffer in circular mode. Each write beat is therefore compared as it happens, and the registers are read back after every boundary item. A sequencer in the wrong state shows within a cycle: a missing write beat, an extra one, or the wrong direction of `bus_we`. A lost enable clear shows only when a later request causes an extra item, so requests keep arriving after the channel has stopped.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_COUNT = 3'd1;
  localparam logic [2:0] RA_PADDR = 3'd2;
  localparam logic [2:0] RA_MADDR = 3'd3;
  localparam logic [2:0] RA_FLAGS = 3'd4;

  // dir[1] set selects memory-to-memory; dir == 1 is memory to peripheral
  localparam logic [1:0] DIR_P2M = 2'd0;
  localparam logic [1:0] DIR_M2P = 2'd1;

  typedef struct packed {
    logic       errie;
    logic       tcie;
    logic       half;
    logic       dec;
    logic       circ;
    logic [1:0] dir;
    logic       en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RD   = 2'd1,
    SQ_WR   = 2'd2
  } sq_state_e;

endpackage

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 16,
  parameter int MW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [MW-1:0] reg_wdata,
  output logic [MW-1:0] reg_rdata,
  input  logic          xfer_done,
  input  logic          xfer_err,
  input  logic [MW-1:0] maddr_nxt,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_base_o,
  output logic [PW-1:0] paddr_o,
  output logic [MW-1:0] maddr_o,
  output logic          tc_o,
  output logic          err_o
);

  ctrl_t         ctrl_q;
  logic [CW-1:0] cnt_q, cnt_base_q;
  logic [PW-1:0] paddr_q;
  logic [MW-1:0] maddr_q, maddr_base_q;
  logic          tc_q, err_q;
  logic          last_item;

  assign last_item = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q       <= '0;
      cnt_q        <= '0;
      cnt_base_q   <= '0;
      paddr_q      <= '0;
      maddr_q      <= '0;
      maddr_base_q <= '0;
      tc_q         <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          RA_CTRL:  ctrl_q <= ctrl_t'(reg_wdata[7:0]);
          RA_COUNT: if (!ctrl_q.en) begin
                      cnt_q      <= reg_wdata[CW-1:0];
                      cnt_base_q <= reg_wdata[CW-1:0];
                    end
          RA_PADDR: paddr_q <= reg_wdata[PW-1:0];
          RA_MADDR: begin
                      maddr_q      <= reg_wdata;
                      maddr_base_q <= reg_wdata;
                    end
          RA_FLAGS: begin
                      tc_q  <= tc_q  & ~reg_wdata[0];
                      err_q <= err_q & ~reg_wdata[1];
                    end
          default: ;
        endcase
      end
      // hardware events take priority over a same-cycle software write
      if (xfer_done) begin
        if (last_item) begin
          tc_q <= 1'b1;
          if (ctrl_q.circ) begin
            cnt_q   <= cnt_base_q;
            maddr_q <= maddr_base_q;
          end else begin
            cnt_q     <= '0;
            maddr_q   <= maddr_nxt;
            ctrl_q.en <= 1'b0;
          end
        end else begin
          cnt_q   <= cnt_q - CW'(1);
          maddr_q <= maddr_nxt;
        end
      end
      if (xfer_err) begin
        err_q     <= 1'b1;
        ctrl_q.en <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = MW'(ctrl_q);
      RA_COUNT: reg_rdata = MW'(cnt_q);
      RA_PADDR: reg_rdata = MW'(paddr_q);
      RA_MADDR: reg_rdata = maddr_q;
      RA_FLAGS: reg_rdata = MW'({err_q, tc_q});
      default:  reg_rdata = '0;
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign cnt_o      = cnt_q;
  assign cnt_base_o = cnt_base_q;
  assign paddr_o    = paddr_q;
  assign maddr_o    = maddr_q;
  assign tc_o       = tc_q;
  assign err_o      = err_q;

endmodule

// File: rtl/dmac_addr_gen.sv
`timescale 1ns/1ps
module dmac_addr_gen #(
  parameter int PW = 16,
  parameter int MW = 24
) (
  input  logic [1:0]    dir,
  input  logic          dec,
  input  logic          half,
  input  logic [PW-1:0] paddr,
  input  logic [MW-1:0] maddr,
  output logic [MW-1:0] src_addr,
  output logic [MW-1:0] dst_addr,
  output logic [MW-1:0] maddr_nxt
);

  logic          m2m, mem_src;
  logic [MW-1:0] maddr_bus, paddr_bus;

  function automatic logic [MW-1:0] step_ptr(input logic [MW-1:0] a,
                                             input logic down,
                                             input logic wide);
    logic [MW-1:0] delta;
    delta = wide ? MW'(2) : MW'(1);
    return down ? (a - delta) : (a + delta);
  endfunction

  assign m2m     = dir[1];
  assign mem_src = dir[1] | dir[0];

  // only the memory-to-memory mode drives the pointer's extension bits
  generate
    if (MW > PW) begin : g_ext
      assign maddr_bus = m2m ? maddr : {{(MW-PW){1'b0}}, maddr[PW-1:0]};
      assign paddr_bus = {{(MW-PW){1'b0}}, paddr};
    end else begin : g_flat
      assign maddr_bus = maddr;
      assign paddr_bus = paddr;
    end
  endgenerate

  assign src_addr  = mem_src ? maddr_bus : paddr_bus;
  assign dst_addr  = mem_src ? paddr_bus : maddr_bus;
  assign maddr_nxt = step_ptr(maddr, dec, half);

endmodule

// File: rtl/dmac_seq.sv
`timescale 1ns/1ps
module dmac_seq
  import dmac_pkg::*;
#(
  parameter int MW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_en,
  input  logic          cnt_nz,
  input  logic          m2m,
  input  logic          half,
  input  logic          periph_req,
  input  logic [MW-1:0] src_addr,
  input  logic [MW-1:0] dst_addr,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [MW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          xfer_done,
  output logic          xfer_err
);

  sq_state_e     state_q;
  logic          pend_q;
  logic [DW-1:0] data_q;
  logic          start;

  function automatic logic [DW-1:0] lane_mask(input logic [DW-1:0] d,
                                              input logic wide);
    return wide ? d : DW'(d[7:0]);
  endfunction

  assign start = go_en && cnt_nz && (m2m || pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      if (!go_en)
        pend_q <= 1'b0;
      else if (state_q == SQ_IDLE && start && !m2m)
        pend_q <= periph_req;
      else if (periph_req)
        pend_q <= 1'b1;

      case (state_q)
        SQ_IDLE: if (start) state_q <= SQ_RD;
        SQ_RD: if (bus_ack) begin
          if (bus_err) state_q <= SQ_IDLE;
          else begin
            data_q  <= lane_mask(bus_rdata, half);
            state_q <= SQ_WR;
          end
        end
        SQ_WR: if (bus_ack) state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign bus_req   = (state_q != SQ_IDLE);
  assign bus_we    = (state_q == SQ_WR);
  assign bus_addr  = (state_q == SQ_WR) ? dst_addr : src_addr;
  assign bus_wdata = data_q;
  assign xfer_done = (state_q == SQ_WR) && bus_ack && !bus_err;
  assign xfer_err  = bus_req && bus_ack && bus_err;

endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine
  import dmac_pkg::*;
#(
  parameter int CW = 8,
  parameter int PW = 16,
  parameter int MW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          glb_en,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [MW-1:0] reg_wdata,
  output logic [MW-1:0] reg_rdata,
  input  logic          periph_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic [MW-1:0] bus_addr,
  output logic          bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_err,
  output logic          tc_flag,
  output logic          err_flag,
  output logic          irq
);

  ctrl_t         ctrl;
  logic [CW-1:0] cnt, cnt_base;
  logic [PW-1:0] paddr;
  logic [MW-1:0] maddr, maddr_nxt, src_addr, dst_addr;
  logic          xfer_done, xfer_err;
  // named internal events for the checker
  logic          ch_en, m2m_mode, half_mode, circ_mode, go_en;

  assign ch_en     = ctrl.en;
  assign m2m_mode  = ctrl.dir[1];
  assign half_mode = ctrl.half;
  assign circ_mode = ctrl.circ;
  assign go_en     = ch_en && glb_en;

  dmac_regs #(.CW(CW), .PW(PW), .MW(MW)) u_regs (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .xfer_done, .xfer_err, .maddr_nxt,
    .ctrl_o(ctrl), .cnt_o(cnt), .cnt_base_o(cnt_base),
    .paddr_o(paddr), .maddr_o(maddr), .tc_o(tc_flag), .err_o(err_flag)
  );

  dmac_addr_gen #(.PW(PW), .MW(MW)) u_addr (
    .dir(ctrl.dir), .dec(ctrl.dec), .half(ctrl.half),
    .paddr, .maddr, .src_addr, .dst_addr, .maddr_nxt
  );

  dmac_seq #(.MW(MW), .DW(DW)) u_seq (
    .clk, .rst_n, .go_en, .cnt_nz(cnt != '0), .m2m(m2m_mode),
    .half(half_mode), .periph_req, .src_addr, .dst_addr,
    .bus_ack, .bus_err, .bus_rdata, .bus_req, .bus_we, .bus_addr,
    .bus_wdata, .xfer_done, .xfer_err
  );

  assign bus_size = half_mode;
  assign irq      = (tc_flag && ctrl.tcie) || (err_flag && ctrl.errie);

endmodule

// File: rtl/dmac_chk.sv
`timescale 1ns/1ps
module dmac_chk #(
  parameter int CW = 8,
  parameter int MW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en,
  input logic          bus_req,
  input logic          bus_we,
  input logic          bus_ack,
  input logic          bus_err,
  input logic [MW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          m2m_mode,
  input logic          half_mode,
  input logic          circ_mode,
  input logic          ch_en,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cnt_base,
  input logic          xfer_done,
  input logic          tc_flag
);

  // R4
  upper_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !m2m_mode) |-> (bus_addr[MW-1:16] == '0));

  // R7
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !half_mode) |-> (bus_wdata[DW-1:8] == '0));

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ch_en) |=> ((cnt == $past(cnt) - 1'b1) || (cnt == $past(cnt_base))));

  // R9
  normal_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !circ_mode && cnt == CW'(1)) |=> !ch_en);

  // R12
  tc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> $past(xfer_done));

  // R13
  err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_err) |=> !bus_req);

  // R11
  global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(glb_en));

endmodule

bind dma_chan_engine dmac_chk #(.CW(CW), .MW(MW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .bus_req(bus_req),
  .bus_we(bus_we), .bus_ack(bus_ack), .bus_err(bus_err),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .m2m_mode(m2m_mode),
  .half_mode(half_mode), .circ_mode(circ_mode), .ch_en(ch_en),
  .cnt(cnt), .cnt_base(cnt_base), .xfer_done(xfer_done), .tc_flag(tc_flag)
);

// File: tb/test_dma_chan_engine.sv
`timescale 1ns/1ps
module test_dma_chan_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        periph_req = 1'b0;
  logic        bus_req, bus_we, bus_size, bus_ack, bus_err;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        tc_flag, err_flag, irq;

  int n_tot = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [23:0] last_rd = '0;
  logic [7:0]  mem [0:4095];

  typedef struct {
    logic [23:0] a;
    logic [15:0] d;
    logic        sz;
    string       tag;
  } item_t;
  item_t exp_q[$];

  always #2 clk = ~clk;

  dma_chan_engine i_dma_chan_engine (
    .clk, .rst_n, .glb_en, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .periph_req, .bus_req, .bus_we, .bus_addr, .bus_size, .bus_wdata,
    .bus_ack, .bus_rdata, .bus_err, .tc_flag, .err_flag, .irq
  );

  // bus slave model: always ready, error on one marked address
  logic [11:0] idx0, idx1;
  assign idx0      = bus_addr[11:0];
  assign idx1      = bus_addr[11:0] + 12'd1;
  assign bus_ack   = bus_req;
  assign bus_err   = bus_req && (bus_addr[15:0] == 16'hBAD0);
  assign bus_rdata = {mem[idx1], mem[idx0]};

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13 + 7) & 255);
  endfunction

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = pat(i);
  end

  always @(posedge clk) begin
    if (bus_req && bus_we && !bus_err) begin
      mem[idx0] = bus_wdata[7:0];
      if (bus_size) mem[idx1] = bus_wdata[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ack) begin
      if (!bus_we) last_rd = bus_addr;
      else if (!bus_err) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write beat", {8'h0, bus_addr}, 32'h0);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(bus_addr == it.a && bus_wdata == it.d && bus_size == it.sz,
              it.tag, {bus_size, 7'h0, bus_addr}, {it.sz, 7'h0, it.a});
          if (bus_wdata != it.d)
            chk(1'b0, {it.tag, " data"}, {16'h0, bus_wdata}, {16'h0, it.d});
        end
      end
    end
  end

  task automatic push_byte(input logic [23:0] dst, input int src, input string tag);
    item_t it;
    it.a = dst; it.d = {8'h00, pat(src)}; it.sz = 1'b0; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic push_half(input logic [23:0] dst, input int src, input string tag);
    item_t it;
    it.a = dst; it.d = {pat(src + 1), pat(src)}; it.sz = 1'b1; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); periph_req = 1'b1;
    @(negedge clk); periph_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    wrap_up();
  end

  initial begin
    logic [23:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    rd(3'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(3'd1, v); chk(v == 0, "R1 count", v, 0);
    rd(3'd4, v); chk(v == 0, "R1 flags", v, 0);
    chk(!bus_req && !irq, "R1 bus_req/irq", {bus_req, irq}, 0);

    // R2 peripheral to memory, byte, increment, normal
    glb_en = 1'b1;
    wr(3'd2, 24'h000040);
    wr(3'd3, 24'h000800);
    wr(3'd1, 24'd3);
    wr(3'd0, 24'h01);
    idle(10);
    rd(3'd1, v); chk(v == 3, "R2 no request no transfer", v, 3);
    push_byte(24'h000800, 'h040, "R2 item0");
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 2, "R8 count after one item", v, 2);
    wr(3'd1, 24'd9);
    rd(3'd1, v); chk(v == 2, "R8 count locked while enabled", v, 2);
    push_byte(24'h000801, 'h040, "R5 item1");
    pulse(); idle(8);
    push_byte(24'h000802, 'h040, "R5 item2");
    pulse(); idle(8);
    rd(3'd0, v); chk(v[0] == 1'b0, "R9 enable cleared", v, 0);
    rd(3'd4, v); chk(v == 1, "R9 complete flag", v, 1);
    rd(3'd3, v); chk(v == 24'h000803, "R5 pointer stepped up", v, 24'h000803);
    rd(3'd2, v); chk(v == 24'h000040, "R5 fixed address kept", v, 24'h40);
    chk(last_rd == 24'h000040, "R2 read from fixed address", last_rd, 24'h40);
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 0, "R9 stopped after zero", v, 0);
    chk(!irq, "R12 irq masked", irq, 0);
    wr(3'd0, 24'h40);
    chk(irq, "R12 irq with enable", irq, 1);
    wr(3'd4, 24'h1);
    rd(3'd4, v); chk(v == 0, "R12 write one clears", v, 0);
    chk(!irq, "R12 irq drops", irq, 0);

    // R3 memory to peripheral, halfword, decrement, circular; R4 upper bits hidden
    wr(3'd2, 24'h000050);
    wr(3'd3, 24'h7F0A10);
    wr(3'd1, 24'd2);
    wr(3'd0, 24'h3B);
    push_half(24'h000050, 'hA10, "R3 R7 item0");
    pulse(); idle(8);
    chk(last_rd == 24'h000A10, "R4 upper address bits zero", last_rd, 24'h000A10);
    push_half(24'h000050, 'hA0E, "R6 item1");
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 2, "R10 count reloaded", v, 2);
    rd(3'd4, v); chk(v == 1, "R10 complete flag", v, 1);
    rd(3'd0, v); chk(v[0] == 1'b1, "R10 still enabled", v, 1);
    push_half(24'h000050, 'hA10, "R10 item after reload");
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 1, "R10 count after reload item", v, 1);
    rd(3'd3, v); chk(v == 24'h7F0A0E, "R6 pointer stepped down", v, 24'h7F0A0E);
    wr(3'd0, 24'h0);
    wr(3'd4, 24'h3);

    // R11 global enable gating
    glb_en = 1'b0;
    wr(3'd2, 24'h000060);
    wr(3'd3, 24'h000980);
    wr(3'd1, 24'd1);
    wr(3'd0, 24'h01);
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 1, "R11 blocked while global off", v, 1);
    glb_en = 1'b1;
    idle(8);
    rd(3'd1, v); chk(v == 1, "R11 request not kept", v, 1);
    push_byte(24'h000980, 'h060, "R11 item");
    pulse(); idle(8);
    rd(3'd1, v); chk(v == 0, "R11 moves once enabled", v, 0);
    wr(3'd4, 24'h1);

    // R4 memory to memory, back to back, 24-bit source
    wr(3'd2, 24'h000C00);
    wr(3'd3, 24'h120300);
    wr(3'd1, 24'd4);
    for (int k = 0; k < 4; k++) push_byte(24'h000C00, 'h300 + k, "R4 m2m item");
    wr(3'd0, 24'h05);
    idle(30);
    rd(3'd1, v); chk(v == 0, "R4 all items moved", v, 0);
    chk(last_rd == 24'h120303, "R4 wide source address", last_rd, 24'h120303);
    rd(3'd3, v); chk(v == 24'h120304, "R5 wide pointer stepped", v, 24'h120304);
    wr(3'd4, 24'h1);

    // R13 bus error
    wr(3'd2, 24'h00BAD0);
    wr(3'd3, 24'h000900);
    wr(3'd1, 24'd2);
    wr(3'd0, 24'h81);
    pulse(); idle(8);
    rd(3'd4, v); chk(v == 2, "R13 error flag", v, 2);
    rd(3'd0, v); chk(v[0] == 1'b0, "R13 enable cleared", v, 0);
    rd(3'd1, v); chk(v == 2, "R13 count unchanged", v, 2);
    chk(irq, "R13 error irq", irq, 1);
    wr(3'd4, 24'h2);
    rd(3'd4, v); chk(v == 0, "R13 error flag cleared", v, 0);
    chk(!irq, "R13 irq drops", irq, 0);

    chk(exp_q.size() == 0, "R2 all expected writes seen", exp_q.size(), 0);
    wrap_up();
  end

endmodule